// File: doc/BRIEF.md
# Serial Receiver with Status Flags and Two-Step Flag Clearing

This block receives asynchronous serial characters on a single input line and holds them for a processor. The line is sampled with an oversampling tick, at OVERSAMPLE ticks per bit. The receiver looks for a start bit and then collects 8 or 9 data bits, least significant bit first. Each bit is decided by a three-sample majority taken around the middle of the bit. The stop bit is checked as well. Receive problems are reported as sticky status flags: data present, overrun, noise, framing error and idle line.

A processor reaches the block through a byte-wide register port with four addresses. Flags are cleared by a two-step sequence. A read of the status register records which flags are set at that moment. A later read of the data register returns the character and clears only those recorded flags. If a new character arrives between the two reads, the recorded set is dropped, so that character's flags cannot be lost. The interrupt request is raised when interrupts are enabled and either a character is waiting or an overrun has happened.

Top module: `sci_rx_core`

## Requirements
- R1: After reset, every status flag, the data register, both control registers and `irq` are 0.
- R2: The register addresses are: format 0, control 1, status 2, data 3. A frame is one start bit (0), 8 data bits (9 when format bit 0 is set) sent LSB first, and one stop bit, so it lasts 10 or 11 bit times. Each received character sets status bit 0 (data present) and loads the data register. In 9-bit mode the ninth bit is readable at format bit 7.
- R3: Every bit is the majority of three samples taken at tick counts OVERSAMPLE/2-1, OVERSAMPLE/2 and OVERSAMPLE/2+1 of the bit. If the three samples of any bit disagree, status bit 3 (noise) is set. A start bit whose majority is 1 is dropped, and no character results.
- R4: A stop bit whose majority is 0 sets status bit 4 (framing error), and the character is still stored.
- R5: A character that completes while data present is set sets status bit 2 (overrun). The new character replaces the old one, and data present stays set.
- R6: A status read records the flags set at that moment. The next data read returns the character and clears only the recorded flags. A data read with no status read before it clears nothing.
- R7: A character that arrives after a status read cancels the recorded set, so the following data read clears no flag.
- R8: Status bit 1 (idle) is set once the line has stayed high for one full frame time after a character. It stays 0 before that time has passed.
- R9: While control bit 0 (receive enable) is 0, no character is received, and the flags and data keep their values. Writes to the status and data addresses have no effect.
- R10: `irq` equals control bit 1 (receive interrupt enable) AND (data present OR overrun).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling tick, OVERSAMPLE ticks per bit |
| rxd | input | 1 | Serial input line, idle high |
| rd_en | input | 1 | Register read strobe; side effects at the clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with OVERSAMPLE set to 8 and the tick held high every clock. Each bit then lasts eight clocks, and an idle frame lasts 80 clocks. This short timing makes many frames, overrun pairs and idle-line waits fit in a short run. It also places the centre sample of each majority vote on one known clock, so a single-clock glitch hits exactly one sample. The bench uses this to test the noise flag while expecting the data to be unchanged.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;

    localparam logic [1:0] ADDR_FMT  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_DATA = 2'd3;

    // status byte layout, bit 0 first: rdrf, idle, ovr, nf, fe
    typedef struct packed {
        logic fe;
        logic nf;
        logic ovr;
        logic idle;
        logic rdrf;
    } rx_flags_t;

    typedef struct packed {
        logic [8:0] data;
        logic       nf;
        logic       fe;
    } rx_char_t;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_BITS = 1'b1
    } rx_state_t;

endpackage

// File: rtl/sci_rx_sampler.sv
module sci_rx_sampler
    import sci_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     nine_bit,
    input  logic     tick,
    input  logic     rxd,
    output logic     char_valid,
    output rx_char_t char_o,
    output logic     idle_evt
);
    localparam int CNT_W      = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam int MID        = OVERSAMPLE / 2;
    localparam int NORM_TICKS = 10 * OVERSAMPLE;
    localparam int WIDE_TICKS = 11 * OVERSAMPLE;
    localparam int IDLE_W     = $clog2(WIDE_TICKS + 1);

    typedef struct packed {
        rx_state_t         st;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        idx;
        logic [1:0]        samp;
        logic [8:0]        shreg;
        logic              noisy;
        logic              done;
        rx_char_t          chr;
        logic              armed;
        logic [IDLE_W-1:0] icnt;
        logic              ievt;
        logic              rxd_s;
    } smp_t;

    smp_t q, d;

    logic       maj, disagree;
    logic [3:0] stop_idx;
    logic [IDLE_W-1:0] idle_limit;

    always_comb begin
        maj        = (q.samp[1] & q.samp[0]) | (q.samp[1] & q.rxd_s) | (q.samp[0] & q.rxd_s);
        disagree   = !((q.samp[1] == q.samp[0]) && (q.samp[0] == q.rxd_s));
        stop_idx   = nine_bit ? 4'd10 : 4'd9;
        idle_limit = nine_bit ? IDLE_W'(WIDE_TICKS - 1) : IDLE_W'(NORM_TICKS - 1);

        d       = q;
        d.done  = 1'b0;
        d.ievt  = 1'b0;
        d.rxd_s = rxd;

        if (!enable) begin
            d.st    = RX_WAIT;
            d.cnt   = '0;
            d.idx   = '0;
            d.armed = 1'b0;
            d.icnt  = '0;
        end else if (tick) begin
            case (q.st)
                RX_WAIT: begin
                    if (!q.rxd_s) begin
                        d.st    = RX_BITS;
                        d.cnt   = CNT_W'(1);
                        d.idx   = '0;
                        d.noisy = 1'b0;
                        d.icnt  = '0;
                    end else if (q.armed) begin
                        if (q.icnt == idle_limit) begin
                            d.ievt  = 1'b1;
                            d.armed = 1'b0;
                            d.icnt  = '0;
                        end else begin
                            d.icnt = q.icnt + 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (q.cnt == CNT_W'(OVERSAMPLE - 1)) begin
                        d.cnt = '0;
                        d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                    if (q.cnt == CNT_W'(MID - 1)) d.samp[1] = q.rxd_s;
                    if (q.cnt == CNT_W'(MID))     d.samp[0] = q.rxd_s;
                    if (q.cnt == CNT_W'(MID + 1)) begin
                        d.noisy = q.noisy | disagree;
                        if (q.idx == 4'd0) begin
                            if (maj) d.st = RX_WAIT;
                        end else if (q.idx == stop_idx) begin
                            d.done     = 1'b1;
                            d.chr.data = nine_bit ? q.shreg : {1'b0, q.shreg[8:1]};
                            d.chr.nf   = q.noisy | disagree;
                            d.chr.fe   = !maj;
                            d.st       = RX_WAIT;
                            d.armed    = 1'b1;
                            d.icnt     = '0;
                        end else begin
                            d.shreg = {maj, q.shreg[8:1]};
                        end
                    end
                end
                default: d.st = RX_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign char_valid = q.done;
    assign char_o     = q.chr;
    assign idle_evt   = q.ievt;

endmodule

// File: rtl/sci_rx_regs.sv
module sci_rx_regs
    import sci_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       char_valid,
    input  rx_char_t   char_i,
    input  logic       idle_evt,
    output logic       rx_en,
    output logic       rie,
    output logic       nine_bit,
    output rx_flags_t  flags,
    output logic       irq
);
    typedef struct packed {
        logic       nine;
        logic       r8;
        logic       rx_en;
        logic       rie;
        rx_flags_t  flg;
        rx_flags_t  cap;
        logic [7:0] data;
    } reg_t;

    reg_t q, d;
    logic stat_rd, data_rd;

    always_comb begin
        stat_rd = rd_en && (addr == ADDR_STAT);
        data_rd = rd_en && (addr == ADDR_DATA);
        d = q;

        if (wr_en) begin
            case (addr)
                ADDR_FMT:  d.nine = wdata[0];
                ADDR_CTRL: begin
                    d.rx_en = wdata[0];
                    d.rie   = wdata[1];
                end
                default: ;
            endcase
        end

        if (stat_rd) d.cap = q.flg;
        if (data_rd) begin
            d.flg = q.flg & ~q.cap;
            d.cap = '0;
        end
        if (idle_evt) d.flg.idle = 1'b1;
        if (char_valid) begin
            d.flg.ovr  = d.flg.ovr | d.flg.rdrf;
            d.flg.rdrf = 1'b1;
            d.flg.nf   = d.flg.nf | char_i.nf;
            d.flg.fe   = d.flg.fe | char_i.fe;
            d.data     = char_i.data[7:0];
            d.r8       = char_i.data[8];
            d.cap      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            ADDR_FMT:  rdata = {q.r8, 6'b0, q.nine};
            ADDR_CTRL: rdata = {6'b0, q.rie, q.rx_en};
            ADDR_STAT: rdata = {3'b0, q.flg};
            default:   rdata = q.data;
        endcase
    end

    assign rx_en    = q.rx_en;
    assign rie      = q.rie;
    assign nine_bit = q.nine;
    assign flags    = q.flg;
    assign irq      = q.rie & (q.flg.rdrf | q.flg.ovr);

endmodule

// File: rtl/sci_rx_core.sv
module sci_rx_core
    import sci_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    logic      char_valid, idle_evt, rx_en, rie, nine_bit;
    rx_char_t  rx_char;
    rx_flags_t rx_flags;

    sci_rx_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .nine_bit   (nine_bit),
        .tick       (tick),
        .rxd        (rxd),
        .char_valid (char_valid),
        .char_o     (rx_char),
        .idle_evt   (idle_evt)
    );

    sci_rx_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .char_valid (char_valid),
        .char_i     (rx_char),
        .idle_evt   (idle_evt),
        .rx_en      (rx_en),
        .rie        (rie),
        .nine_bit   (nine_bit),
        .flags      (rx_flags),
        .irq        (irq)
    );

endmodule

// File: rtl/sci_rx_core_chk.sv
module sci_rx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       char_valid,
    input logic       rdrf,
    input logic       ovr,
    input logic       rx_en,
    input logic       rie,
    input logic       irq
);
    logic data_rd;
    assign data_rd = rd_en && (addr == 2'd3);

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rdrf && !data_rd) |=> ovr);

    // R2
    rdrf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> rdrf);

    // R9
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !char_valid);

    // R6
    rdrf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_valid && !data_rd) |=> $stable(rdrf));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rie);

endmodule

bind sci_rx_core sci_rx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .char_valid (char_valid),
    .rdrf       (rx_flags.rdrf),
    .ovr        (rx_flags.ovr),
    .rx_en      (rx_en),
    .rie        (rie),
    .irq        (irq)
);

// File: tb/sci_rx_core_test.sv
module sci_rx_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int OS = 8;
    localparam logic [1:0] A_FMT = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq;

    int checks = 0, fails = 0;
    bit mon_on = 0, mon_busy = 0, finished = 0;
    logic [10:0] exp_q[$];  // {fe, nf, data9}

    always #(CLK_PERIOD/2) clk = ~clk;

    sci_rx_core #(.OVERSAMPLE(OS)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_frame(input logic [8:0] val, input bit nine, input bit stop, input int glitch);
        int last;
        last = nine ? 10 : 9;
        for (int b = 0; b <= last; b++) begin
            logic bv;
            bv = (b == 0) ? 1'b0 : (b == last) ? stop : val[b-1];
            for (int m = 0; m < OS; m++) begin
                @(negedge clk);
                rxd = (b == glitch && m == OS/2) ? ~bv : bv;
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic flush();
        logic [7:0] t;
        repeat (120) @(negedge clk);
        bus_read(A_STAT, t);
        bus_read(A_DATA, t);
    endtask

    // scoreboard monitor
    initial begin
        logic [10:0] e;
        logic [7:0] s, f, dv;
        forever begin
            @(negedge clk);
            if (mon_on && irq && exp_q.size() > 0) begin
                mon_busy = 1;
                e = exp_q.pop_front();
                bus_read(A_STAT, s);
                check(s[0] == 1'b1, "R2 rdrf on arrival", {8'h0, s}, 16'h1);
                check(s[3] == e[9], "R3 noise flag", {15'h0, s[3]}, {15'h0, e[9]});
                check(s[4] == e[10], "R4 framing flag", {15'h0, s[4]}, {15'h0, e[10]});
                bus_read(A_FMT, f);
                check(f[7] == e[8], "R2 ninth bit", {15'h0, f[7]}, {15'h0, e[8]});
                bus_read(A_DATA, dv);
                check(dv == e[7:0], "R2 data byte", {8'h0, dv}, {8'h0, e[7:0]});
                check(irq == 1'b0, "R10 irq after clear", {15'h0, irq}, 16'h0);
                mon_busy = 0;
            end
        end
    end

    task automatic wait_mon();
        while (exp_q.size() > 0 || mon_busy) @(negedge clk);
    endtask

    task automatic sb_frame(input logic [8:0] v, input bit nine, input int glitch);
        exp_q.push_back({1'b0, glitch >= 0, nine ? v : {1'b0, v[7:0]}});
        send_frame(v, nine, 1'b1, glitch);
        wait_mon();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_FMT, s);  check(s == 8'h00, "R1 format reset", {8'h0, s}, 16'h0);
        bus_read(A_CTRL, s); check(s == 8'h00, "R1 control reset", {8'h0, s}, 16'h0);
        bus_read(A_STAT, s); check(s == 8'h00, "R1 status reset", {8'h0, s}, 16'h0);
        bus_read(A_DATA, s); check(s == 8'h00, "R1 data reset", {8'h0, s}, 16'h0);
        check(irq == 1'b0, "R1 irq reset", {15'h0, irq}, 16'h0);

        // scoreboard phase, 8-bit then 9-bit
        bus_write(A_CTRL, 8'h03);
        mon_on = 1;
        sb_frame(9'h0A5, 0, -1);
        sb_frame(9'h03C, 0, -1);
        sb_frame(9'h000, 0, -1);
        sb_frame(9'h0FF, 0, -1);
        mon_on = 0;
        bus_write(A_FMT, 8'h01);
        mon_on = 1;
        sb_frame(9'h1A5, 1, -1);
        sb_frame(9'h05A, 1, -1);
        sb_frame(9'h155, 1, 2);
        mon_on = 0;
        bus_write(A_FMT, 8'h00);
        flush();

        // R3 noise on 8-bit directed, data kept by majority
        send_frame(9'h00F, 0, 1'b1, 6);
        bus_read(A_STAT, s); check(s[3] == 1'b1, "R3 glitch sets noise", {8'h0, s}, 16'h9);
        bus_read(A_DATA, s); check(s == 8'h0F, "R3 majority data", {8'h0, s}, 16'h0F);
        flush();

        // R4 framing error
        send_frame(9'h081, 0, 1'b0, -1);
        bus_read(A_STAT, s); check(s[4] && s[0], "R4 framing flag set", {8'h0, s}, 16'h11);
        bus_read(A_DATA, s); check(s == 8'h81, "R4 char kept", {8'h0, s}, 16'h81);
        bus_read(A_STAT, s); check((s & 8'h1D) == 8'h00, "R4 cleared by sequence", {8'h0, s}, 16'h0);
        flush();

        // R5 overrun
        send_frame(9'h011, 0, 1'b1, -1);
        send_frame(9'h022, 0, 1'b1, -1);
        check(irq == 1'b1, "R10 irq with data", {15'h0, irq}, 16'h1);
        bus_read(A_STAT, s); check(s[0] && s[2], "R5 overrun flag", {8'h0, s}, 16'h5);
        bus_read(A_DATA, s); check(s == 8'h22, "R5 newest char", {8'h0, s}, 16'h22);
        bus_read(A_STAT, s); check((s & 8'h05) == 8'h00, "R5 overrun cleared", {8'h0, s}, 16'h0);
        check(irq == 1'b0, "R10 irq cleared", {15'h0, irq}, 16'h0);
        flush();

        // R6 data read without a status read clears nothing
        send_frame(9'h033, 0, 1'b1, -1);
        bus_read(A_DATA, s); check(s == 8'h33, "R6 data value", {8'h0, s}, 16'h33);
        bus_read(A_STAT, s); check(s[0] == 1'b1, "R6 no status read, rdrf kept", {8'h0, s}, 16'h1);
        flush();

        // R7 arrival cancels capture
        send_frame(9'h044, 0, 1'b1, -1);
        bus_read(A_STAT, s);
        send_frame(9'h055, 0, 1'b1, -1);
        bus_read(A_DATA, s); check(s == 8'h55, "R7 second char", {8'h0, s}, 16'h55);
        bus_read(A_STAT, s); check(s[0] && s[2], "R7 nothing cleared", {8'h0, s}, 16'h5);
        flush();

        // R6 / R8 only captured flags cleared; idle set later
        send_frame(9'h066, 0, 1'b1, -1);
        bus_read(A_STAT, s); check(s[1] == 1'b0, "R8 idle not yet", {8'h0, s}, 16'h1);
        repeat (120) @(negedge clk);
        bus_read(A_DATA, s); check(s == 8'h66, "R6 data returned", {8'h0, s}, 16'h66);
        bus_read(A_STAT, s); check(s[1:0] == 2'b10, "R6 R8 idle kept, rdrf cleared", {8'h0, s}, 16'h2);
        bus_read(A_DATA, s);
        bus_read(A_STAT, s); check(s[1] == 1'b0, "R8 idle cleared by sequence", {8'h0, s}, 16'h0);

        // R10 interrupt gating
        send_frame(9'h077, 0, 1'b1, -1);
        bus_write(A_CTRL, 8'h01);
        @(negedge clk); check(irq == 1'b0, "R10 rie off", {15'h0, irq}, 16'h0);
        bus_write(A_CTRL, 8'h03);
        @(negedge clk); check(irq == 1'b1, "R10 rie on", {15'h0, irq}, 16'h1);

        // R9 receiver disabled, writes to status/data ignored
        bus_write(A_CTRL, 8'h00);
        send_frame(9'h099, 0, 1'b1, -1);
        bus_write(A_STAT, 8'h00);
        bus_write(A_DATA, 8'h12);
        bus_read(A_STAT, s); check(s[0] == 1'b1 && s[2] == 1'b0, "R9 flags kept", {8'h0, s}, 16'h1);
        bus_read(A_DATA, s); check(s == 8'h77, "R9 data kept", {8'h0, s}, 16'h77);

        // R3 false start dropped
        bus_write(A_CTRL, 8'h03);
        flush();
        @(negedge clk) rxd = 1'b0;
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        repeat (100) @(negedge clk);
        bus_read(A_STAT, s); check(s[0] == 1'b0, "R3 false start ignored", {8'h0, s}, 16'h0);
        send_frame(9'h05A, 0, 1'b1, -1);
        bus_read(A_STAT, s); check(s[0] == 1'b1, "R3 receive after false start", {8'h0, s}, 16'h1);
        bus_read(A_DATA, s); check(s == 8'h5A, "R3 data after false start", {8'h0, s}, 16'h5A);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule